// File: doc/BRIEF.md
# Accumulator Core with Five Operand Addressing Modes

This block is a small sequencer built around an accumulator. It fetches 32-bit instruction words from a single synchronous memory port and decodes each one. It then executes the instruction, using one of five ways to form the operand: the operand field used as a value, the field used as an address, the field used as a pointer to a full-width address, the field plus an index register, or the field as a signed offset from the incremented program counter. Instructions and data share the same port. The memory returns a word one cycle after a read is issued.

Each instruction word has two fields. The opcode occupies bits 31:20. The operand occupies bits 19:0 and is sign-extended wherever it is used as a value or an offset. All addresses are cut down to the low `AW` bits, which matches a memory of 2^AW words. The index register can be loaded, decremented and tested by a relative branch. Together these form array loops that count down to below zero. The accumulator, program counter and a halted flag are brought out as status outputs. An asynchronous active-low reset restarts the core at address 0. The core leaves reset two clock edges after `rst_n` is released.

Top module: `accm_core`

## Requirements
- R1: While in reset, and until the first fetch, `acc` reads 0, `pc` reads 0 and `halted` reads 0. The first instruction is fetched from address 0 on the third rising edge after `rst_n` is released.
- R2: Every instruction is read from address `pc`, and `pc` advances by one on that fetch edge. The opcode is in bits 31:20 and the operand field is in bits 19:0. The opcodes are: 0x001 immediate load, 0x002 direct load, 0x003 indirect load, 0x004 indexed load, 0x005 indexed add, 0x006 relative load, 0x007 index set, 0x008 index decrement, 0x009 relative jump, 0x00A branch-if-index-not-negative, and 0x0FF halt.
- R3: The immediate load (0x001) puts the sign-extended operand field into `acc` and issues no data read. It takes 3 cycles.
- R4: The direct load (0x002) puts the word at the operand field (taken modulo the depth) into `acc`. It takes 3 cycles.
- R5: The indirect load (0x003) first reads the word at the operand field. It then uses that whole word, taken modulo the depth, as the address of a second read, and the result goes to `acc`. It takes 4 cycles, one more than the direct load.
- R6: The indexed load (0x004) reads the word at operand field plus index register into `acc`. The indexed add (0x005) adds that word to `acc`. The latched instruction word is never modified.
- R7: The relative load (0x006) reads the word at the incremented `pc` plus the sign-extended operand into `acc`, and leaves `pc` unchanged.
- R8: The index set (0x007) loads the sign-extended operand into the index register. The index decrement (0x008) subtracts one from it. The index register changes at no other time.
- R9: The relative jump (0x009) sets `pc` to the incremented `pc` plus the sign-extended operand.
- R10: Opcode 0x00A jumps like 0x009 when bit 31 of the index register is clear. Otherwise execution falls through to the next word.
- R11: Opcode 0x0FF and every opcode not listed in R2 raise `halted` after 3 cycles. After that no memory reads are issued and `acc` and `pc` hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd | output | 1 | Read request to memory this cycle |
| mem_addr | output | AW | Read address |
| mem_rdata | input | 32 | Word returned one cycle after a read |
| acc | output | 32 | Accumulator |
| pc | output | AW | Program counter |
| halted | output | 1 | Core has stopped |

## Verification
The checks assume the memory behind the port returns the addressed word exactly one cycle after `mem_rd` and never changes while a program runs. Under that assumption a word fetched as code always decodes the same way in the decode and execute cycles. The stimulus uses a bench memory with precisely that latency, loads each program while reset is held, and never writes it afterwards. The programs avoid jumping into data words, so every cycle of a run is predicted by the instruction-level model.

// File: rtl/accm_pkg.sv
package accm_pkg;
  localparam int WORD_W = 32;
  localparam int OPC_W  = 12;
  localparam int FLD_W  = 20;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_ADDR,
    ST_EXEC,
    ST_HALT
  } state_t;

  typedef logic [OPC_W-1:0] opc_t;

  localparam opc_t OP_LDM    = 12'h001;
  localparam opc_t OP_LDD    = 12'h002;
  localparam opc_t OP_LDI    = 12'h003;
  localparam opc_t OP_LDX    = 12'h004;
  localparam opc_t OP_ADX    = 12'h005;
  localparam opc_t OP_LDR    = 12'h006;
  localparam opc_t OP_LDIX   = 12'h007;
  localparam opc_t OP_DECX   = 12'h008;
  localparam opc_t OP_JMPR   = 12'h009;
  localparam opc_t OP_JPNNEG = 12'h00A;
  localparam opc_t OP_HLT    = 12'h0FF;

  function automatic logic [WORD_W-1:0] sext_fld(input logic [FLD_W-1:0] f);
    return {{(WORD_W-FLD_W){f[FLD_W-1]}}, f};
  endfunction

  // true for opcodes that keep the core running after execute
  function automatic logic opc_runs(input opc_t o);
    return (o >= OP_LDM) && (o <= OP_JPNNEG);
  endfunction
endpackage

// File: rtl/accm_agen.sv
module accm_agen
  import accm_pkg::*;
#(
  parameter int AW = 10
) (
  input  state_t            state,
  input  logic [WORD_W-1:0] rdata,
  input  logic [AW-1:0]     pc,
  input  logic [WORD_W-1:0] xr,
  output logic [AW-1:0]     addr,
  output logic              rd
);
  localparam int PADW = WORD_W - AW;

  opc_t              opc;
  logic [FLD_W-1:0]  fld;
  logic [WORD_W-1:0] fld_z;
  logic [WORD_W-1:0] pc_z;

  assign opc   = rdata[WORD_W-1 -: OPC_W];
  assign fld   = rdata[FLD_W-1:0];
  assign fld_z = {{(WORD_W-FLD_W){1'b0}}, fld};
  assign pc_z  = {{PADW{1'b0}}, pc};

  // effective address: fetch, first operand read in decode, pointer read in ADDR
  always_comb begin
    rd   = 1'b0;
    addr = '0;
    unique case (state)
      ST_FETCH: begin
        rd   = 1'b1;
        addr = pc;
      end
      ST_DECODE: begin
        unique case (opc)
          OP_LDD, OP_LDI: begin
            rd   = 1'b1;
            addr = AW'(fld_z);
          end
          OP_LDX, OP_ADX: begin
            rd   = 1'b1;
            addr = AW'(fld_z + xr);
          end
          OP_LDR: begin
            rd   = 1'b1;
            addr = AW'(pc_z + sext_fld(fld));
          end
          default: ;
        endcase
      end
      ST_ADDR: begin
        rd   = 1'b1;
        addr = AW'(rdata);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/accm_ctrl.sv
module accm_ctrl
  import accm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  opc_t   dec_opc,
  input  opc_t   cir_opc,
  output state_t state
);
  state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: nxt = (dec_opc == OP_LDI) ? ST_ADDR : ST_EXEC;
      ST_ADDR:   nxt = ST_EXEC;
      ST_EXEC:   nxt = opc_runs(cir_opc) ? ST_FETCH : ST_HALT;
      default:   nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= nxt;
  end
endmodule

// File: rtl/accm_dpath.sv
module accm_dpath
  import accm_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  state_t            state,
  input  logic [WORD_W-1:0] rdata,
  output logic [AW-1:0]     pc,
  output logic [WORD_W-1:0] cir,
  output logic [WORD_W-1:0] acc,
  output logic [WORD_W-1:0] xr
);
  opc_t              opc;
  logic [WORD_W-1:0] disp;
  logic              pc_en, cir_en, acc_en, xr_en;
  logic [AW-1:0]     pc_d;
  logic [WORD_W-1:0] acc_d, xr_d;

  assign opc  = cir[WORD_W-1 -: OPC_W];
  assign disp = sext_fld(cir[FLD_W-1:0]);

  always_comb begin
    pc_en  = 1'b0;
    pc_d   = pc + AW'(1);
    acc_en = 1'b0;
    acc_d  = rdata;
    xr_en  = 1'b0;
    xr_d   = xr - WORD_W'(1);
    cir_en = (state == ST_DECODE);
    if (state == ST_FETCH) pc_en = 1'b1;
    if (state == ST_EXEC) begin
      unique case (opc)
        OP_LDM: begin
          acc_en = 1'b1;
          acc_d  = disp;
        end
        OP_LDD, OP_LDI, OP_LDX, OP_LDR: acc_en = 1'b1;
        OP_ADX: begin
          acc_en = 1'b1;
          acc_d  = acc + rdata;
        end
        OP_LDIX: begin
          xr_en = 1'b1;
          xr_d  = disp;
        end
        OP_DECX: xr_en = 1'b1;
        OP_JMPR: begin
          pc_en = 1'b1;
          pc_d  = pc + AW'(disp);
        end
        OP_JPNNEG: begin
          pc_en = ~xr[WORD_W-1];
          pc_d  = pc + AW'(disp);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      cir <= '0;
      acc <= '0;
      xr  <= '0;
    end else begin
      if (pc_en)  pc  <= pc_d;
      if (cir_en) cir <= rdata;
      if (acc_en) acc <= acc_d;
      if (xr_en)  xr  <= xr_d;
    end
  end
endmodule

// File: rtl/accm_core.sv
module accm_core
  import accm_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] acc,
  output logic [AW-1:0]     pc,
  output logic              halted
);
  logic [1:0]        rst_pipe;
  logic              core_rst_n;
  state_t            st;
  logic [WORD_W-1:0] cir_q;
  logic [WORD_W-1:0] xr_q;

  // reset asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  accm_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .dec_opc (mem_rdata[WORD_W-1 -: OPC_W]),
    .cir_opc (cir_q[WORD_W-1 -: OPC_W]),
    .state   (st)
  );

  accm_agen #(.AW(AW)) u_agen (
    .state (st),
    .rdata (mem_rdata),
    .pc    (pc),
    .xr    (xr_q),
    .addr  (mem_addr),
    .rd    (mem_rd)
  );

  accm_dpath #(.AW(AW)) u_dpath (
    .clk   (clk),
    .rst_n (core_rst_n),
    .state (st),
    .rdata (mem_rdata),
    .pc    (pc),
    .cir   (cir_q),
    .acc   (acc),
    .xr    (xr_q)
  );

  assign halted = (st == ST_HALT);
endmodule

// File: rtl/accm_chk.sv
module accm_chk
  import accm_pkg::*;
#(
  parameter int AW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input state_t            state,
  input logic [WORD_W-1:0] cir,
  input logic [WORD_W-1:0] xr,
  input logic [AW-1:0]     pc,
  input logic              mem_rd,
  input logic [AW-1:0]     mem_addr,
  input logic              halted
);
  p_fetch_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |-> (mem_rd && mem_addr == pc));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |=> (pc == AW'($past(pc) + AW'(1))));

  p_addr_only_ldi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR) |-> (cir[WORD_W-1 -: OPC_W] == OP_LDI));

  p_addr_to_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR) |=> (state == ST_EXEC));

  p_cir_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_DECODE) |=> $stable(cir));

  p_xr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_EXEC) |=> $stable(xr));

  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc)));

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_rd);
endmodule

bind accm_core accm_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (core_rst_n),
  .state    (st),
  .cir      (cir_q),
  .xr       (xr_q),
  .pc       (pc),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr),
  .halted   (halted)
);

// File: tb/accm_core_bench.sv
module accm_core_bench;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  localparam logic [11:0] O_LDM = 12'h001, O_LDD = 12'h002, O_LDI = 12'h003,
                          O_LDX = 12'h004, O_ADX = 12'h005, O_LDR = 12'h006,
                          O_SETX = 12'h007, O_DECX = 12'h008, O_JMP = 12'h009,
                          O_BNN = 12'h00A, O_HLT = 12'h0FF;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_rdata;
  logic [31:0]   acc;
  logic [AW-1:0] pc;
  logic          halted;

  logic [31:0] mem [DEPTH];

  always #2 clk = ~clk;

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  accm_core #(.AW(AW)) u_accm_core (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .acc(acc), .pc(pc), .halted(halted)
  );

  int total = 0;
  int bad   = 0;
  bit cmp_on = 1'b0;
  logic [31:0]   m_acc, m_xr;
  logic [AW-1:0] m_pc;
  bit            m_halt;
  string         m_tag;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (cmp_on) begin
    chk(acc === m_acc, {m_tag, " acc"}, acc, m_acc);
    chk(pc === m_pc, {m_tag, " pc"}, 32'(pc), 32'(m_pc));
    chk(halted === m_halt, {m_tag, " halted"}, 32'(halted), 32'(m_halt));
  end

  function automatic logic [31:0] mk(input logic [11:0] op, input logic [19:0] f);
    return {op, f};
  endfunction

  function automatic string tag_of(input logic [11:0] op);
    case (op)
      O_LDM:          return "R3";
      O_LDD:          return "R4";
      O_LDI:          return "R5";
      O_LDX, O_ADX:   return "R6";
      O_LDR:          return "R7";
      O_SETX, O_DECX: return "R8";
      O_JMP:          return "R9";
      O_BNN:          return "R10";
      default:        return "R11";
    endcase
  endfunction

  task automatic begin_prog();
    @(negedge clk);
    #1;
    rst_n  = 1'b0;
    m_acc  = '0;
    m_xr   = '0;
    m_pc   = '0;
    m_halt = 1'b0;
    m_tag  = "R1";
    cmp_on = 1'b1;
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  // one instruction of the model, starting at its fetch edge
  task automatic step();
    logic [31:0] w, sx;
    logic [11:0] op;
    logic [19:0] f;
    @(posedge clk);
    w = mem[m_pc];
    m_pc = m_pc + 1'b1;
    op = w[31:20];
    f  = w[19:0];
    sx = {{12{f[19]}}, f};
    m_tag = tag_of(op);
    @(posedge clk);
    if (op == O_LDI) @(posedge clk);
    @(posedge clk);
    case (op)
      O_LDM:  m_acc = sx;
      O_LDD:  m_acc = mem[AW'(f)];
      O_LDI:  m_acc = mem[AW'(mem[AW'(f)])];
      O_LDX:  m_acc = mem[AW'(32'(f) + m_xr)];
      O_ADX:  m_acc = m_acc + mem[AW'(32'(f) + m_xr)];
      O_LDR:  m_acc = mem[AW'(m_pc + AW'(sx))];
      O_SETX: m_xr = sx;
      O_DECX: m_xr = m_xr - 1;
      O_JMP:  m_pc = m_pc + AW'(sx);
      O_BNN:  if (!m_xr[31]) m_pc = m_pc + AW'(sx);
      default: m_halt = 1'b1;
    endcase
  endtask

  task automatic run_prog();
    repeat (2) @(negedge clk);
    chk(acc === 32'd0, "R1 reset acc", acc, 32'd0);
    chk(pc === '0, "R1 reset pc", 32'(pc), 32'd0);
    chk(halted === 1'b0, "R1 reset halted", 32'(halted), 32'd0);
    #1;
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    while (!m_halt) step();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    // program A: immediate, direct, indirect, indexed, relative loads
    begin_prog();
    mem[0] = mk(O_LDM, 20'hFFFFB);
    mem[1] = mk(O_LDD, 20'd117);
    mem[2] = mk(O_LDI, 20'd117);
    mem[3] = mk(O_SETX, 20'd3);
    mem[4] = mk(O_LDX, 20'd117);
    mem[5] = mk(O_LDR, 20'd2);
    mem[6] = mk(O_HLT, 20'd0);
    mem[8] = 32'h1234_5678;
    mem[117] = 32'd200;
    mem[120] = 32'h0000_00DC;
    mem[200] = 32'h0000_00CF;
    run_prog();
    chk(acc === 32'h1234_5678, "R7 final acc", acc, 32'h1234_5678);
    chk(pc === 10'd7, "R11 halt pc", 32'(pc), 32'd7);
    chk(halted === 1'b1, "R11 halted", 32'(halted), 32'd1);

    // program B: counted-down indexed sum, branch and forward jump
    begin_prog();
    mem[0] = mk(O_LDM, 20'd0);
    mem[1] = mk(O_SETX, 20'd3);
    mem[2] = mk(O_ADX, 20'd100);
    mem[3] = mk(O_DECX, 20'd0);
    mem[4] = mk(O_BNN, 20'hFFFFD);
    mem[5] = mk(O_JMP, 20'd1);
    mem[6] = mk(O_LDM, 20'd99);
    mem[7] = mk(O_HLT, 20'd0);
    mem[100] = 32'd10;
    mem[101] = 32'd20;
    mem[102] = 32'd30;
    mem[103] = 32'd40;
    run_prog();
    chk(acc === 32'd100, "R6 R10 loop sum", acc, 32'd100);
    chk(pc === 10'd8, "R9 jump skip pc", 32'(pc), 32'd8);

    // program C: truncated pointer, jump, unknown opcode
    begin_prog();
    mem[0] = mk(O_LDI, 20'h00428);
    mem[1] = mk(O_JMP, 20'd2);
    mem[2] = mk(O_LDM, 20'd7);
    mem[3] = mk(O_LDM, 20'd7);
    mem[4] = 32'h0AB0_0000;
    mem[40] = 32'hFFFF_F0C8;
    mem[200] = 32'h0000_0055;
    run_prog();
    chk(acc === 32'h55, "R5 full-width pointer", acc, 32'h55);
    chk(pc === 10'd5, "R9 R11 unknown halt pc", 32'(pc), 32'd5);
    chk(halted === 1'b1, "R11 unknown opcode halts", 32'(halted), 32'd1);

    cmp_on = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule